// File: doc/BRIEF.md
# Conversion Window Monitor and Status Flags

This block watches the stream of completed analog-to-digital conversions. For each one it checks the unsigned raw sample against a programmable window formed by an upper and a lower boundary. If the sample lies outside the window, it raises a sticky out-of-range flag. Window checking can be switched on separately for ordinary-group and preempted-group conversions. It can cover every channel, or be narrowed to one channel chosen by a select field. The comparison always uses the raw sample as it arrives; offset correction and alignment are applied elsewhere.

The block also keeps sticky status flags for the start events of both groups and for the end of conversions in each group. Three of the flags have their own interrupt enables. The enabled flags are merged into one local interrupt, and that is ORed with the interrupt of a sibling converter so that both share a single line. Software clears a flag by writing a 0 to its bit. Decoding of the register bus is done outside this block.

Top module: `conv_window_mon`

## Requirements
- R1: After reset every bit of `flags` is 0, and `irq_line` equals `peer_irq`.
- R2: A completed conversion (`conv_done`=1) with `conv_grp`=0 (ordinary) sets `flags[1]`. One with `conv_grp`=1 (preempted) sets `flags[2]`. The bit is visible one clock after the strobe.
- R3: A pulse on `ord_start` sets `flags[3]` and a pulse on `pre_start` sets `flags[4]`, one clock later.
- R4: `flags[0]` is set when the 12-bit unsigned `conv_raw` is strictly greater than `win_hi` or strictly less than `win_lo`. A sample equal to either boundary counts as inside the window.
- R5: Window checking applies to ordinary conversions only when `mon_ord_en`=1, and to preempted conversions only when `mon_pre_en`=1. With the enable for a group at 0, no conversion of that group sets `flags[0]`.
- R6: With `mon_single`=1, only a conversion whose `conv_chan` equals `mon_chan` (5 bits, 0 to 31) can set `flags[0]`. With `mon_single`=0, every channel is checked.
- R7: Flags are sticky. A flag bit stays set until a cycle with `clr_we`=1 and a 0 in the matching bit of `clr_val`. A 1 in `clr_val` leaves that flag unchanged.
- R8: When a set event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: The local interrupt is the OR of `flags[0]&ie_oor`, `flags[1]&ie_conv_end` and `flags[2]&ie_pre_end`. The interrupt follows the flags in the same cycle. The start flags never raise it.
- R10: `irq_line` is the OR of the local interrupt and `peer_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_grp | input | 1 | Group of the completed conversion: 0 ordinary, 1 preempted |
| conv_chan | input | 5 | Channel number of the completed conversion |
| conv_raw | input | 12 | Raw conversion result, before offset and alignment |
| ord_start | input | 1 | Ordinary group conversion start event |
| pre_start | input | 1 | Preempted group conversion start event |
| mon_ord_en | input | 1 | Enable window checking for ordinary conversions |
| mon_pre_en | input | 1 | Enable window checking for preempted conversions |
| mon_single | input | 1 | 1: check only channel `mon_chan`; 0: check all channels |
| mon_chan | input | 5 | Channel selected for single-channel checking |
| win_hi | input | 12 | Upper window boundary |
| win_lo | input | 12 | Lower window boundary |
| ie_oor | input | 1 | Interrupt enable for the out-of-range flag |
| ie_conv_end | input | 1 | Interrupt enable for the ordinary conversion-end flag |
| ie_pre_end | input | 1 | Interrupt enable for the preempted conversion-end flag |
| clr_we | input | 1 | Software write strobe for the flag register |
| clr_val | input | 5 | Written value; a 0 clears the matching flag |
| peer_irq | input | 1 | Interrupt of the sibling converter |
| flags | output | 5 | Status flags: [0] out of range, [1] ordinary end, [2] preempted end, [3] ordinary start, [4] preempted start |
| irq_line | output | 1 | Shared interrupt line |

## Verification
A broken window comparison or group/channel gate shows at `flags[0]` one clock after the strobe. The table covers each boundary value and each gate position, so an off-by-one or a swapped enable shows up as a mismatch on a named vector. A flag register that loses its value, ignores a clear or lets a clear win shows up in the first sample taken after that write. Interrupt merge faults show at `irq_line` in the same cycle that the enables or the flags change.

// File: rtl/cwm_pkg.sv
package cwm_pkg;

   localparam int FLAG_N    = 5;
   localparam int F_OOR     = 0;
   localparam int F_CEND    = 1;
   localparam int F_PEND    = 2;
   localparam int F_OSTART  = 3;
   localparam int F_PSTART  = 4;
   localparam int IRQ_SRC_N = 3;

   typedef enum logic {
      GRP_ORD = 1'b0,
      GRP_PRE = 1'b1
   } grp_e;

endpackage

// File: rtl/cwm_window_cmp.sv
module cwm_window_cmp #(
   parameter int DATA_W = 12,
   parameter int CH_W   = 5
) (
   input  logic              conv_done,
   input  logic              conv_grp,
   input  logic [CH_W-1:0]   conv_chan,
   input  logic [DATA_W-1:0] conv_raw,
   input  logic              ord_en,
   input  logic              pre_en,
   input  logic              single,
   input  logic [CH_W-1:0]   sel_chan,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   output logic              oor_hit
);
   import cwm_pkg::*;

   logic grp_ok;
   logic chan_ok;
   logic above;
   logic below;

   always_comb begin
      grp_ok  = (grp_e'(conv_grp) == GRP_PRE) ? pre_en : ord_en;
      chan_ok = !single || (conv_chan == sel_chan);
      above   = conv_raw > hi;
      below   = conv_raw < lo;
      oor_hit = conv_done && grp_ok && chan_ok && (above || below);
   end

endmodule

// File: rtl/cwm_flag_bank.sv
module cwm_flag_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_we,
   input  logic [N-1:0] clr_val,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic clr_bit;
      assign clr_bit = clr_we && !clr_val[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_vec[i])
            flags[i] <= 1'b1;
         else if (clr_bit)
            flags[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/cwm_irq_merge.sv
module cwm_irq_merge #(
   parameter int N_SRC   = 3,
   parameter int IRQ_REG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] en,
   input  logic             peer,
   output logic             irq_line
);

   logic local_irq;

   if (IRQ_REG == 0) begin : g_comb
      assign local_irq = |(src & en);
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) local_irq <= 1'b0;
         else        local_irq <= |(src & en);
      end
   end

   assign irq_line = local_irq | peer;

endmodule

// File: rtl/conv_window_mon.sv
module conv_window_mon #(
   parameter int DATA_W  = 12,
   parameter int CH_W    = 5,
   parameter int IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic              conv_grp,
   input  logic [CH_W-1:0]   conv_chan,
   input  logic [DATA_W-1:0] conv_raw,
   input  logic              ord_start,
   input  logic              pre_start,
   input  logic              mon_ord_en,
   input  logic              mon_pre_en,
   input  logic              mon_single,
   input  logic [CH_W-1:0]   mon_chan,
   input  logic [DATA_W-1:0] win_hi,
   input  logic [DATA_W-1:0] win_lo,
   input  logic              ie_oor,
   input  logic              ie_conv_end,
   input  logic              ie_pre_end,
   input  logic              clr_we,
   input  logic [4:0]        clr_val,
   input  logic              peer_irq,
   output logic [4:0]        flags,
   output logic              irq_line
);
   import cwm_pkg::*;

   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_data_w
      $error("conv_window_mon: DATA_W out of range");
   end
   if (CH_W < 1 || CH_W > 8) begin : g_bad_ch_w
      $error("conv_window_mon: CH_W out of range");
   end
   if (IRQ_REG < 0 || IRQ_REG > 1) begin : g_bad_irq_reg
      $error("conv_window_mon: IRQ_REG must be 0 or 1");
   end

   logic              oor_hit;
   logic [FLAG_N-1:0] set_vec;
   logic [IRQ_SRC_N-1:0] irq_src;
   logic [IRQ_SRC_N-1:0] irq_en;

   cwm_window_cmp #(
      .DATA_W(DATA_W),
      .CH_W  (CH_W)
   ) u_cmp (
      .conv_done(conv_done),
      .conv_grp (conv_grp),
      .conv_chan(conv_chan),
      .conv_raw (conv_raw),
      .ord_en   (mon_ord_en),
      .pre_en   (mon_pre_en),
      .single   (mon_single),
      .sel_chan (mon_chan),
      .hi       (win_hi),
      .lo       (win_lo),
      .oor_hit  (oor_hit)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[F_OOR]    = oor_hit;
      set_vec[F_CEND]   = conv_done && (grp_e'(conv_grp) == GRP_ORD);
      set_vec[F_PEND]   = conv_done && (grp_e'(conv_grp) == GRP_PRE);
      set_vec[F_OSTART] = ord_start;
      set_vec[F_PSTART] = pre_start;
   end

   cwm_flag_bank #(
      .N(FLAG_N)
   ) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_we (clr_we),
      .clr_val(clr_val),
      .flags  (flags)
   );

   assign irq_src = {flags[F_PEND], flags[F_CEND], flags[F_OOR]};
   assign irq_en  = {ie_pre_end, ie_conv_end, ie_oor};

   cwm_irq_merge #(
      .N_SRC  (IRQ_SRC_N),
      .IRQ_REG(IRQ_REG)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (irq_src),
      .en      (irq_en),
      .peer    (peer_irq),
      .irq_line(irq_line)
   );

endmodule

// File: rtl/cwm_chk.sv
module cwm_chk #(
   parameter int DATA_W  = 12,
   parameter int CH_W    = 5,
   parameter int IRQ_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_done,
   input logic              conv_grp,
   input logic [CH_W-1:0]   conv_chan,
   input logic [DATA_W-1:0] conv_raw,
   input logic              ord_start,
   input logic              pre_start,
   input logic              mon_ord_en,
   input logic              mon_pre_en,
   input logic              mon_single,
   input logic [CH_W-1:0]   mon_chan,
   input logic [DATA_W-1:0] win_hi,
   input logic [DATA_W-1:0] win_lo,
   input logic              ie_oor,
   input logic              ie_conv_end,
   input logic              ie_pre_end,
   input logic              clr_we,
   input logic [4:0]        clr_val,
   input logic              peer_irq,
   input logic [4:0]        flags,
   input logic              irq_line
);

   // R2
   ord_end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !conv_grp) |=> flags[1]);

   // R2
   pre_end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && conv_grp) |=> flags[2]);

   // R3
   start_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_start && pre_start) |=> (flags[3] && flags[4]));

   // R4
   in_window_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[0] && (!conv_done || (conv_raw <= win_hi && conv_raw >= win_lo))) |=> !flags[0]);

   // R5
   group_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[0] && (!conv_done || (conv_grp ? !mon_pre_en : !mon_ord_en))) |=> !flags[0]);

   // R6
   single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[0] && (!conv_done || (mon_single && conv_chan != mon_chan))) |=> !flags[0]);

   // R7
   sticky_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(clr_we && !clr_val[0])) |=> flags[0]);

   // R7
   clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !clr_val[3] && !ord_start) |=> !flags[3]);

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !clr_val[4] && pre_start) |=> flags[4]);

   // R10
   peer_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      peer_irq |-> irq_line);

   if (IRQ_REG == 0) begin : g_comb_irq
      // R9
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((flags[0] && ie_oor) || (flags[1] && ie_conv_end) || (flags[2] && ie_pre_end)) |-> irq_line);
      // R9
      irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!peer_irq && !(flags[0] && ie_oor) && !(flags[1] && ie_conv_end) && !(flags[2] && ie_pre_end)) |-> !irq_line);
   end

endmodule

bind conv_window_mon cwm_chk #(
   .DATA_W (DATA_W),
   .CH_W   (CH_W),
   .IRQ_REG(IRQ_REG)
) u_cwm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_done  (conv_done),
   .conv_grp   (conv_grp),
   .conv_chan  (conv_chan),
   .conv_raw   (conv_raw),
   .ord_start  (ord_start),
   .pre_start  (pre_start),
   .mon_ord_en (mon_ord_en),
   .mon_pre_en (mon_pre_en),
   .mon_single (mon_single),
   .mon_chan   (mon_chan),
   .win_hi     (win_hi),
   .win_lo     (win_lo),
   .ie_oor     (ie_oor),
   .ie_conv_end(ie_conv_end),
   .ie_pre_end (ie_pre_end),
   .clr_we     (clr_we),
   .clr_val    (clr_val),
   .peer_irq   (peer_irq),
   .flags      (flags),
   .irq_line   (irq_line)
);

// File: tb/conv_window_mon_bench.sv
module conv_window_mon_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   typedef struct packed {
      logic        grp;
      logic        oen;
      logic        pen;
      logic        single;
      logic [4:0]  sel;
      logic [4:0]  chan;
      logic [11:0] raw;
      logic        exp_oor;
   } vec_t;

   localparam int NV = 12;
   // window fixed at lo=0x100, hi=0x800 for the table
   localparam vec_t TAB [NV] = '{
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd0,  12'h900, 1'b1},
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd1,  12'h800, 1'b0},
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd2,  12'h100, 1'b0},
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd2,  12'h0FF, 1'b1},
      '{1'b1, 1'b1, 1'b0, 1'b0, 5'd0,  5'd7,  12'hFFF, 1'b0},
      '{1'b1, 1'b0, 1'b1, 1'b0, 5'd0,  5'd7,  12'hFFF, 1'b1},
      '{1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  5'd9,  12'h000, 1'b0},
      '{1'b0, 1'b1, 1'b1, 1'b1, 5'd3,  5'd3,  12'hA00, 1'b1},
      '{1'b0, 1'b1, 1'b1, 1'b1, 5'd3,  5'd4,  12'hA00, 1'b0},
      '{1'b1, 1'b1, 1'b1, 1'b1, 5'd31, 5'd31, 12'h050, 1'b1},
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd5,  12'h801, 1'b1},
      '{1'b0, 1'b1, 1'b0, 1'b0, 5'd0,  5'd5,  12'h7FF, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_done = 1'b0, conv_grp = 1'b0;
   logic [4:0]  conv_chan = '0;
   logic [11:0] conv_raw = '0;
   logic        ord_start = 1'b0, pre_start = 1'b0;
   logic        mon_ord_en = 1'b0, mon_pre_en = 1'b0, mon_single = 1'b0;
   logic [4:0]  mon_chan = '0;
   logic [11:0] win_hi = 12'h800, win_lo = 12'h100;
   logic        ie_oor = 1'b0, ie_conv_end = 1'b0, ie_pre_end = 1'b0;
   logic        clr_we = 1'b0;
   logic [4:0]  clr_val = '1;
   logic        peer_irq = 1'b0;
   logic [4:0]  flags;
   logic        irq_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   conv_window_mon u_conv_window_mon (
      .clk(clk), .rst_n(rst_n),
      .conv_done(conv_done), .conv_grp(conv_grp), .conv_chan(conv_chan), .conv_raw(conv_raw),
      .ord_start(ord_start), .pre_start(pre_start),
      .mon_ord_en(mon_ord_en), .mon_pre_en(mon_pre_en), .mon_single(mon_single), .mon_chan(mon_chan),
      .win_hi(win_hi), .win_lo(win_lo),
      .ie_oor(ie_oor), .ie_conv_end(ie_conv_end), .ie_pre_end(ie_pre_end),
      .clr_we(clr_we), .clr_val(clr_val), .peer_irq(peer_irq),
      .flags(flags), .irq_line(irq_line)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle write of the flag register with value v
   task automatic wr_flags(input logic [4:0] v);
      @(negedge clk);
      clr_we = 1'b1; clr_val = v;
      @(negedge clk);
      clr_we = 1'b0; clr_val = '1;
   endtask

   task automatic conv(input logic g, input logic [4:0] c, input logic [11:0] r);
      @(negedge clk);
      conv_done = 1'b1; conv_grp = g; conv_chan = c; conv_raw = r;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 flags in reset", {27'd0, flags}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags after reset", {27'd0, flags}, 32'd0);
      chk("R1 irq after reset", {31'd0, irq_line}, 32'd0);

      // table walk: R2 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr_flags(5'b00000);
         mon_ord_en = TAB[i].oen; mon_pre_en = TAB[i].pen;
         mon_single = TAB[i].single; mon_chan = TAB[i].sel;
         conv(TAB[i].grp, TAB[i].chan, TAB[i].raw);
         chk($sformatf("R4/R5/R6 vec %0d oor", i), {31'd0, flags[0]}, {31'd0, TAB[i].exp_oor});
         chk($sformatf("R2 vec %0d end flags", i), {30'd0, flags[2:1]},
             TAB[i].grp ? 32'd2 : 32'd1);
      end

      // R3: start events
      wr_flags(5'b00000);
      @(negedge clk); ord_start = 1'b1;
      @(negedge clk); ord_start = 1'b0;
      chk("R3 ordinary start", {27'd0, flags}, 32'h08);
      @(negedge clk); pre_start = 1'b1;
      @(negedge clk); pre_start = 1'b0;
      chk("R3 preempted start", {27'd0, flags}, 32'h18);

      // R7: sticky oor across an in-range conversion, write-1 ignored, write-0 clears
      mon_ord_en = 1'b1; mon_single = 1'b0;
      conv(1'b0, 5'd0, 12'hF00);
      conv(1'b0, 5'd0, 12'h400);
      chk("R7 sticky oor", {31'd0, flags[0]}, 32'd1);
      wr_flags(5'b11111);
      chk("R7 write ones ignored", {27'd0, flags}, 32'h1B);
      wr_flags(5'b11110);
      chk("R7 write zero clears bit0", {27'd0, flags}, 32'h1A);

      // R8: set and clear in the same cycle
      @(negedge clk);
      clr_we = 1'b1; clr_val = 5'b00000;
      conv_done = 1'b1; conv_grp = 1'b1; conv_raw = 12'h400;
      @(negedge clk);
      clr_we = 1'b0; clr_val = '1; conv_done = 1'b0;
      chk("R8 set wins over clear", {27'd0, flags}, 32'h04);

      // R9: interrupt merge
      wr_flags(5'b00000);
      ord_start = 1'b1; pre_start = 1'b1;
      @(negedge clk); ord_start = 1'b0; pre_start = 1'b0;
      ie_oor = 1'b1; ie_conv_end = 1'b1; ie_pre_end = 1'b1;
      #1;
      chk("R9 start flags give no irq", {31'd0, irq_line}, 32'd0);
      ie_oor = 1'b0;
      conv(1'b0, 5'd0, 12'hF00);
      ie_conv_end = 1'b0; ie_pre_end = 1'b0;
      #1;
      chk("R9 disabled oor no irq", {31'd0, irq_line}, 32'd0);
      ie_oor = 1'b1;
      #1;
      chk("R9 enabled oor irq", {31'd0, irq_line}, 32'd1);
      ie_oor = 1'b0; ie_conv_end = 1'b1;
      #1;
      chk("R9 enabled conv end irq", {31'd0, irq_line}, 32'd1);
      wr_flags(5'b11101);
      chk("R9 irq drops after clear", {31'd0, irq_line}, 32'd0);

      // R10: peer interrupt
      peer_irq = 1'b1;
      #1;
      chk("R10 peer drives line", {31'd0, irq_line}, 32'd1);
      peer_irq = 1'b0;
      #1;
      chk("R10 line low without sources", {31'd0, irq_line}, 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule